// File: doc/BRIEF.md
# Fixed-Constant AES-Round Permutation Core

This block computes a fixed, unkeyed 128-bit permutation. It is built from twelve AES encryption rounds whose round keys are public constants derived from a round counter. The rounds come in pairs. The first round of each pair adds a sparse constant key, which depends on the pair index and on a block-count constant of one. The second round of each pair adds an all-zero key, so that round has no key addition at all.

The reference form of the permutation runs MixColumns in all twelve rounds and finishes with one InvMixColumns. This core gives the same result another way: it skips MixColumns in the twelfth round and has no inverse stage.

A single round datapath is reused, one round per clock. A caller waits for `ready`, pulses `start` with the input word, and reads `dataOut` when `done` pulses twelve cycles later. The result stays on `dataOut` until the next accepted start.

Top module: `fixperm_core`

## Requirements
- R1: After reset, `ready` is 1, `done` is 0 and `dataOut` is all zeros.
- R2: A start accepted on a rising edge with `ready` high makes `done` high for exactly one cycle, after the twelfth following rising edge, and at no other time.
- R3: From the accepted start until `done`, `ready` is 0. A `start` raised during that time is ignored: the result and the `done` timing belong to the original input, and no extra `done` follows.
- R4: State byte i (i = 0..15) sits in bits [127-8i -: 8], and column j holds bytes 4j..4j+3. Outer round c runs from 1 to 6. In outer round c, the first AES round (S-box, row r rotated left by r, MixColumns) adds key bytes 0, 4, 8 and 12 equal to 0x00, 0x10, 0x20 and 0x30, each XORed with c and with 1, and all other key bytes are zero. The second AES round adds nothing. There is no initial key addition.
- R5: For any input, `dataOut` at `done` equals twelve full rounds with MixColumns in each, followed by one InvMixColumns.
- R6: `dataOut` holds its value from `done` until the next accepted start.
- R7: A start raised in the same cycle as `done` is accepted, and its own result follows twelve cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a permutation; taken when `ready` is high |
| dataIn | input | 128 | Input word, sampled with an accepted start |
| ready | output | 1 | Core is idle and can accept a start |
| done | output | 1 | One-cycle pulse: `dataOut` holds the result |
| dataOut | output | 128 | Permutation state / result |

## Verification
Every cycle, the assertions check the control sequencing:
- a pass of rounds is never cut short;
- `done` is a single-cycle pulse that arrives only when the core is idle;
- load and step never happen together;
- the state register stays frozen when neither happens.

The numerical correctness of the result can only be shown by the bench scenarios. These cover the key schedule, the S-box, the row rotation and the equivalence of skipping the last MixColumns with applying the inverse at the end. The bench compares against an independently written model that uses the full-mix-plus-inverse form. The same holds for back-to-back starts and for starts raised while the core is busy.

// File: rtl/fixperm_pkg.sv
package fixperm_pkg;

  typedef struct packed {
    logic       load;
    logic       step;
    logic       addKey;
    logic       mixCols;
    logic [7:0] outerIdx;
  } fixpermStrobes_t;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] x;
    acc = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ x;
      x = xtime(x);
    end
    return acc;
  endfunction

  // multiplicative inverse as x^254 (maps 0 to 0)
  function automatic logic [7:0] gfInv(input logic [7:0] a);
    logic [7:0] sq;
    logic [7:0] r;
    sq = a;
    r = 8'h01;
    for (int i = 1; i < 8; i++) begin
      sq = gfMul(sq, sq);
      r = gfMul(r, sq);
    end
    return r;
  endfunction

  function automatic logic [7:0] sboxByte(input logic [7:0] a);
    logic [7:0] v;
    v = gfInv(a);
    return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
             ^ {v[3:0], v[7:4]} ^ 8'h63;
  endfunction

endpackage

// File: rtl/fixperm_round.sv
module fixperm_round
  import fixperm_pkg::*;
#(
  parameter int BLOCK_COUNT = 1
) (
  input  logic [127:0] stateIn,
  input  logic [7:0]   outerIdx,
  input  logic         addKey,
  input  logic         mixCols,
  output logic [127:0] roundOut
);
  localparam int NUM_BYTES = 16;
  localparam int NUM_COLS  = 4;

  logic [7:0] subB [NUM_BYTES];
  logic [7:0] shB  [NUM_BYTES];
  logic [7:0] mixB [NUM_BYTES];
  logic [7:0] keyB [NUM_BYTES];

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_sub
    assign subB[i] = sboxByte(stateIn[127-8*i -: 8]);
  end

  for (genvar col = 0; col < NUM_COLS; col++) begin : g_col
    for (genvar row = 0; row < 4; row++) begin : g_row
      assign shB[row + 4*col] = subB[row + 4*((col + row) % NUM_COLS)];
    end

    logic [7:0] a0, a1, a2, a3;
    assign a0 = shB[4*col];
    assign a1 = shB[4*col+1];
    assign a2 = shB[4*col+2];
    assign a3 = shB[4*col+3];

    assign mixB[4*col]   = mixCols ? (xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3) : a0;
    assign mixB[4*col+1] = mixCols ? (a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3) : a1;
    assign mixB[4*col+2] = mixCols ? (a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3) : a2;
    assign mixB[4*col+3] = mixCols ? (xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3)) : a3;

    // sparse constant key: only the top byte of each column is non-zero
    assign keyB[4*col]   = addKey ? (8'(16*col) ^ outerIdx ^ 8'(BLOCK_COUNT)) : 8'h00;
    assign keyB[4*col+1] = 8'h00;
    assign keyB[4*col+2] = 8'h00;
    assign keyB[4*col+3] = 8'h00;
  end

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_out
    assign roundOut[127-8*i -: 8] = mixB[i] ^ keyB[i];
  end

endmodule

// File: rtl/fixperm_ctrl.sv
module fixperm_ctrl
  import fixperm_pkg::*;
#(
  parameter int NUM_OUTER = 6
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  output logic            ready,
  output logic            done,
  output fixpermStrobes_t strobes
);
  localparam int NUM_ROUNDS = 2 * NUM_OUTER;
  localparam int RW = $clog2(NUM_ROUNDS);
  localparam logic [RW-1:0] LAST = RW'(NUM_ROUNDS - 1);

  logic          busy;
  logic [RW-1:0] rnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      rnd  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        if (rnd == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
        rnd <= rnd + 1'b1;
      end else if (start) begin
        busy <= 1'b1;
        rnd  <= '0;
      end
    end
  end

  assign ready = !busy;

  always_comb begin
    strobes.load     = start && !busy;
    strobes.step     = busy;
    strobes.addKey   = !rnd[0];
    strobes.mixCols  = (rnd != LAST);
    strobes.outerIdx = 8'(rnd >> 1) + 8'd1;
  end

  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_keep_running_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && rnd != LAST) |=> (busy && !done));

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/fixperm_datapath.sv
module fixperm_datapath
  import fixperm_pkg::*;
#(
  parameter int BLOCK_COUNT = 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  fixpermStrobes_t strobes,
  input  logic [127:0]    dataIn,
  output logic [127:0]    dataOut
);
  logic [127:0] stateQ;
  logic [127:0] roundOut;

  fixperm_round #(.BLOCK_COUNT(BLOCK_COUNT)) u_round (
    .stateIn (stateQ),
    .outerIdx(strobes.outerIdx),
    .addKey  (strobes.addKey),
    .mixCols (strobes.mixCols),
    .roundOut(roundOut)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= '0;
    else if (strobes.load) stateQ <= dataIn;
    else if (strobes.step) stateQ <= roundOut;
  end

  assign dataOut = stateQ;

  assert_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |-> !strobes.load);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && !strobes.step) |=> $stable(stateQ));

endmodule

// File: rtl/fixperm_core.sv
module fixperm_core
  import fixperm_pkg::*;
#(
  parameter int NUM_OUTER   = 6,
  parameter int BLOCK_COUNT = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [127:0] dataIn,
  output logic         ready,
  output logic         done,
  output logic [127:0] dataOut
);
  fixpermStrobes_t strobes;

  fixperm_ctrl #(.NUM_OUTER(NUM_OUTER)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .ready  (ready),
    .done   (done),
    .strobes(strobes)
  );

  fixperm_datapath #(.BLOCK_COUNT(BLOCK_COUNT)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .dataIn (dataIn),
    .dataOut(dataOut)
  );

endmodule

// File: tb/fixperm_core_test.sv
module fixperm_core_test;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN;
  logic         start;
  logic [127:0] dataIn;
  logic         ready;
  logic         done;
  logic [127:0] dataOut;

  int checks = 0;
  int failures = 0;
  logic [7:0] sTbl [256];
  logic [63:0] seed = 64'h243f6a8885a308d3;

  always #(CLK_PERIOD/2) clk = ~clk;

  fixperm_core uut (.clk(clk), .rstN(rstN), .start(start), .dataIn(dataIn),
                    .ready(ready), .done(done), .dataOut(dataOut));

  function automatic logic [7:0] mulB(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 8'h00;
    logic [7:0] x = a;
    for (int k = 0; k < 8; k++) begin
      logic hi;
      if (b[k]) p ^= x;
      hi = x[7];
      x = x << 1;
      if (hi) x ^= 8'h1b;
    end
    return p;
  endfunction

  function automatic logic [127:0] refRound(input logic [127:0] s, input int c, input bit keyed);
    logic [7:0] a [16];
    logic [7:0] t [16];
    logic [127:0] r;
    for (int i = 0; i < 16; i++) a[i] = sTbl[s[127-8*i -: 8]];
    for (int i = 0; i < 16; i++) t[i] = a[(i % 4) + 4*(((i / 4) + (i % 4)) % 4)];
    for (int j = 0; j < 4; j++) begin
      a[4*j]   = mulB(t[4*j],2) ^ mulB(t[4*j+1],3) ^ t[4*j+2] ^ t[4*j+3];
      a[4*j+1] = t[4*j] ^ mulB(t[4*j+1],2) ^ mulB(t[4*j+2],3) ^ t[4*j+3];
      a[4*j+2] = t[4*j] ^ t[4*j+1] ^ mulB(t[4*j+2],2) ^ mulB(t[4*j+3],3);
      a[4*j+3] = mulB(t[4*j],3) ^ t[4*j+1] ^ t[4*j+2] ^ mulB(t[4*j+3],2);
      if (keyed) a[4*j] ^= 8'(j*16) ^ 8'(c) ^ 8'h01;
    end
    for (int i = 0; i < 16; i++) r[127-8*i -: 8] = a[i];
    return r;
  endfunction

  function automatic logic [127:0] refPerm(input logic [127:0] din);
    logic [127:0] s = din;
    logic [7:0] t [16];
    for (int c = 1; c <= 6; c++) begin
      s = refRound(s, c, 1'b1);
      s = refRound(s, c, 1'b0);
    end
    for (int i = 0; i < 16; i++) t[i] = s[127-8*i -: 8];
    for (int j = 0; j < 4; j++) begin
      s[127-8*(4*j)   -: 8] = mulB(t[4*j],14) ^ mulB(t[4*j+1],11) ^ mulB(t[4*j+2],13) ^ mulB(t[4*j+3],9);
      s[127-8*(4*j+1) -: 8] = mulB(t[4*j],9) ^ mulB(t[4*j+1],14) ^ mulB(t[4*j+2],11) ^ mulB(t[4*j+3],13);
      s[127-8*(4*j+2) -: 8] = mulB(t[4*j],13) ^ mulB(t[4*j+1],9) ^ mulB(t[4*j+2],14) ^ mulB(t[4*j+3],11);
      s[127-8*(4*j+3) -: 8] = mulB(t[4*j],11) ^ mulB(t[4*j+1],13) ^ mulB(t[4*j+2],9) ^ mulB(t[4*j+3],14);
    end
    return s;
  endfunction

  function automatic logic [127:0] nextRand();
    logic [127:0] v;
    for (int h = 0; h < 2; h++) begin
      seed ^= seed << 13; seed ^= seed >> 7; seed ^= seed << 17;
      v = {v[63:0], seed};
    end
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // start already accepted at the previous edge; ends at the negedge where done is high
  task automatic waitDone(input logic [127:0] expOut, input string req);
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      if (i < 12) begin
        check(!done, "R2 early done", 128'(done), 128'(0));
        check(!ready, "R3 ready while busy", 128'(ready), 128'(0));
      end else begin
        check(done, "R2 done at cycle 12", 128'(done), 128'(1));
        check(dataOut == expOut, req, dataOut, expOut);
      end
    end
  endtask

  task automatic runOp(input logic [127:0] din, input string req);
    @(negedge clk);
    check(ready, "R7 ready before start", 128'(ready), 128'(1));
    start = 1'b1; dataIn = din;
    @(negedge clk);
    start = 1'b0; dataIn = ~din;
    waitDone(refPerm(din), req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL R2 watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [127:0] va;
    logic [127:0] vb;
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv = 8'h00;
      for (int y = 1; y < 256; y++) if (mulB(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      sTbl[x] = inv ^ {inv[6:0],inv[7]} ^ {inv[5:0],inv[7:6]} ^ {inv[4:0],inv[7:5]}
              ^ {inv[3:0],inv[7:4]} ^ 8'h63;
    end

    rstN = 1'b0; start = 1'b0; dataIn = '0;
    repeat (3) @(negedge clk);
    check(ready, "R1 ready after reset", 128'(ready), 128'(1));
    check(!done, "R1 done after reset", 128'(done), 128'(0));
    check(dataOut == '0, "R1 dataOut after reset", dataOut, '0);
    rstN = 1'b1;

    // R4: structured patterns exercising key bytes, S-box and row rotation
    runOp('0, "R4 zero input");
    runOp('1, "R4 all-ones input");
    runOp(128'h000102030405060708090a0b0c0d0e0f, "R4 byte ramp");
    for (int i = 0; i < 16; i++) runOp(128'h01 << (8*(15-i)), "R4 single byte");
    for (int i = 0; i < 16; i++) runOp(128'h80 << (8*i), "R4 single high bit");

    // R5: random inputs against full-mix-plus-inverse form
    for (int n = 0; n < 60; n++) runOp(nextRand(), "R5 random input");

    // R6: output held while idle
    va = dataOut;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(dataOut == va, "R6 output held", dataOut, va);
      check(!done, "R2 no extra done", 128'(done), 128'(0));
    end

    // R3: start raised while busy is ignored
    va = nextRand(); vb = nextRand();
    @(negedge clk);
    start = 1'b1; dataIn = va;
    @(negedge clk);
    start = 1'b0;
    for (int i = 1; i <= 12; i++) begin
      if (i == 5) begin start = 1'b1; dataIn = vb; end
      if (i == 7) start = 1'b0;
      @(negedge clk);
      if (i == 12) begin
        check(done, "R3 done timing kept", 128'(done), 128'(1));
        check(dataOut == refPerm(va), "R3 result of first input", dataOut, refPerm(va));
      end else check(!done, "R3 no early done", 128'(done), 128'(0));
    end
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      check(!done, "R3 ignored start gives no done", 128'(done), 128'(0));
    end

    // R7: start in the done cycle
    va = nextRand(); vb = nextRand();
    @(negedge clk);
    start = 1'b1; dataIn = va;
    @(negedge clk);
    start = 1'b0;
    waitDone(refPerm(va), "R5 first of back-to-back");
    check(ready, "R7 ready in done cycle", 128'(ready), 128'(1));
    start = 1'b1; dataIn = vb;
    @(negedge clk);
    start = 1'b0;
    waitDone(refPerm(vb), "R7 back-to-back result");
    @(negedge clk);
    check(!done, "R2 pulse one cycle", 128'(done), 128'(0));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule